// File: doc/BRIEF.md
# S/PDIF Audio Transmitter

This block turns a stream of 16-bit PCM words (alternating left and right) into a biphase-mark coded S/PDIF line on one output bit. Words enter a small first-in first-out store. At the start of every frame the transmitter takes one left/right pair from that store. If fewer than two words are waiting, it sends a silent pair flagged as invalid instead, so the line never stalls.

The line clock is the bus clock divided by an integer set in a register. Each line-clock tick emits one half-cell, and a 32-slot subframe therefore lasts 64 ticks. A second register holds the sample-rate code and four single-bit status flags. These are spread, one bit per frame, over the channel-status slot of a 192-frame block. The mode field shifts each 16-bit word inside the 24-bit audio field, which serves sinks that expect anything from 16-bit to 24-bit justification.

Top module: `spdif_tx`

## Requirements
- R1: After reset the line is low and `smp_ready` is low. The control word (address 0) reads 0. The status word (address 1) reads 0x00000001: rate code 1, which means 48 kHz, and all flags clear.
- R2: While transmitting, one half-cell is emitted per line tick, and a line tick occurs every 1 + ratio bus cycles. The first tick falls 1 + ratio cycles after the edge that sets the transmit enable. `spdif_out` changes on no other cycle, except when the transmit enable drops.
- R3: With the transmit enable clear, `spdif_out` is low from the next cycle on. Setting the enable always starts a new block at frame 0, left subframe.
- R4: A subframe has 32 slots of two half-cells each. In slots 4 to 31 the line toggles at the start of every slot and toggles again mid-slot when the slot bit is 1.
- R5: Slots 0 to 3 carry a preamble of eight half-cells. The time-ordered patterns are 11101000 for the first left subframe of each 192-frame block, 11100010 for every other left subframe, and 11100100 for right subframes. A pattern is inverted when the line was high just before it.
- R6: The audio field occupies slots 4 to 27, LSB first. It holds the 16-bit word shifted left by the mode value, with modes above 8 treated as 8. Mode 0 therefore puts the word in slots 4..19, and mode 8 puts it in slots 12..27.
- R7: Slot 28 (validity) is 1 for fill samples and 0 for stored ones. Slot 29 (user) is 0. Slot 31 makes the count of ones in slots 4..31 even.
- R8: In both subframes of frame f, slot 30 carries one bit of the channel-status word. Frame 1 carries the non-audio flag, frame 2 the copy flag, frame 3 the pre-emphasis flag and frame 15 the generation flag. Frames 24 and 25 carry the rate code mapped as 0→(0,0), 1→(0,1), 2→(1,1), 3→(1,0). Every other frame carries 0.
- R9: A word is accepted when `smp_valid` and `smp_ready` are both high. `smp_ready` is high while the buffer enable is set and fewer than FIFO_DEPTH words are held. At the first tick of each left subframe, the two oldest words become the left and right samples if at least two are held. Otherwise both samples of that frame are zero fill.
- R10: With the buffer enable clear, `smp_ready` is low, offered words are dropped, and stored words are discarded.
- R11: Register writes take effect on the clock edge and read back unchanged. Address 0 holds: [0] transmit enable, [1] buffer enable, [11:4] ratio, [19:16] mode. Address 1 holds: [1:0] rate code, [4] non-audio, [5] copy permitted, [6] pre-emphasis, [7] generation status. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status fields |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| smp_valid | input | 1 | Sample word offered |
| smp_data | input | 16 | Sample word, left and right alternating |
| smp_ready | output | 1 | Sample store can accept a word |
| spdif_out | output | 1 | Biphase-mark coded line |

## Verification
Five properties are checked on every cycle:
- the line idles low when transmission is disabled;
- the line moves only on a tick or a disable;
- the line is low at each preamble start, which holds only if every subframe has even parity;
- the stored-word count stays bounded and is cleared by a buffer disable;
- the frame index stays within the block.

The exact preamble shapes, the biphase decoding of every slot, and the audio placement for each mode can only be shown by the bench, which decodes the captured line. The same holds for the channel-status bits across a full 192-frame block, the fill and validity behaviour once the store runs dry, and the register readback.

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int FIFO_DEPTH = 8,
  parameter int FRAMES     = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  output logic        smp_ready,
  output logic        spdif_out
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int FW = $clog2(FRAMES);
  localparam logic [7:0] PRE_B = 8'h17;
  localparam logic [7:0] PRE_M = 8'h47;
  localparam logic [7:0] PRE_W = 8'h27;

  logic       tx_en, buf_en, f_na, f_cp, f_pe, f_gen;
  logic [7:0] ratio;
  logic [3:0] mode;
  logic [1:0] freq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_en <= 1'b0; buf_en <= 1'b0; ratio <= '0; mode <= '0;
      freq <= 2'd1; f_na <= 1'b0; f_cp <= 1'b0; f_pe <= 1'b0; f_gen <= 1'b0;
    end else if (reg_we) begin
      if (!reg_addr) begin
        tx_en  <= reg_wdata[0];
        buf_en <= reg_wdata[1];
        ratio  <= reg_wdata[11:4];
        mode   <= reg_wdata[19:16];
      end else begin
        freq  <= reg_wdata[1:0];
        f_na  <= reg_wdata[4];
        f_cp  <= reg_wdata[5];
        f_pe  <= reg_wdata[6];
        f_gen <= reg_wdata[7];
      end
    end

  assign reg_rdata = reg_addr ? {24'b0, f_gen, f_pe, f_cp, f_na, 2'b0, freq}
                              : {12'b0, mode, 4'b0, ratio, 2'b0, buf_en, tx_en};

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:20], reg_wdata[15:12], reg_wdata[3:2]};

  // sample store
  logic [15:0]   mem [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop, tick, start;

  assign smp_ready = buf_en && (cnt < CW'(FIFO_DEPTH));
  assign push      = smp_valid && smp_ready;

  always_ff @(posedge clk)
    if (push) mem[wp] <= smp_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (!buf_en) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(2);
      cnt <= cnt + CW'(push) - (pop ? CW'(2) : CW'(0));
    end

  // line timing and framing
  logic [7:0]    div;
  logic [5:0]    hc;
  logic          sub, line, plev, cur_fill;
  logic [FW-1:0] frame;
  logic [15:0]   cur_l, cur_r;

  assign tick  = tx_en && (div == ratio);
  assign start = tick && (hc == 6'd0) && !sub;
  assign pop   = start && (cnt >= CW'(2));

  logic [3:0]  eff_mode;
  logic [23:0] audio;
  logic        cs;
  logic [31:0] body;
  logic [7:0]  pat;
  logic        nxt;

  assign eff_mode = (mode > 4'd8) ? 4'd8 : mode;
  assign audio    = {8'b0, (sub ? cur_r : cur_l)} << eff_mode;

  always_comb begin
    cs = 1'b0;
    case (int'(frame))
      1:  cs = f_na;
      2:  cs = f_cp;
      3:  cs = f_pe;
      15: cs = f_gen;
      24: cs = freq[1];
      25: cs = freq[1] ^ freq[0];
      default: cs = 1'b0;
    endcase
  end

  always_comb begin
    body        = '0;
    body[27:4]  = audio;
    body[28]    = cur_fill;
    body[29]    = 1'b0;
    body[30]    = cs;
    body[31]    = ^body[30:4];
  end

  assign pat = sub ? PRE_W : ((frame == '0) ? PRE_B : PRE_M);

  always_comb
    if (hc < 6'd8)   nxt = pat[hc[2:0]] ^ ((hc == 6'd0) ? line : plev);
    else if (!hc[0]) nxt = ~line;
    else             nxt = line ^ body[hc[5:1]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0; hc <= '0; sub <= 1'b0; frame <= '0; line <= 1'b0; plev <= 1'b0;
      cur_l <= '0; cur_r <= '0; cur_fill <= 1'b1;
    end else if (!tx_en) begin
      div <= '0; hc <= '0; sub <= 1'b0; frame <= '0; line <= 1'b0; plev <= 1'b0;
    end else begin
      div <= tick ? '0 : div + 8'd1;
      if (tick) begin
        line <= nxt;
        hc   <= hc + 6'd1;
        if (hc == 6'd0) plev <= line;
        if (hc == 6'd63) begin
          sub <= ~sub;
          if (sub) frame <= (frame == FW'(FRAMES - 1)) ? '0 : frame + FW'(1);
        end
        if (start) begin
          cur_l    <= pop ? mem[rp] : 16'h0;
          cur_r    <= pop ? mem[rp + AW'(1)] : 16'h0;
          cur_fill <= !pop;
        end
      end
    end

  assign spdif_out = line;

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !spdif_out);
  a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spdif_out) |-> ($past(tick) || $past(!tx_en)));
  a_r7_even_subframe: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hc == 6'd0) |-> !spdif_out);
  a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FIFO_DEPTH));
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> (cnt == '0));
  a_r5_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame) < FRAMES);
endmodule

// File: tb/spdif_tx_tb.sv
module spdif_tx_tb_top;
  localparam int CLK_NS = 20;
  localparam int DEPTH  = 8;
  localparam int NFR    = 192;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_ready, spdif_out;

  always #(CLK_NS/2) clk = ~clk;

  spdif_tx #(.FIFO_DEPTH(DEPTH), .FRAMES(NFR)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_ready(smp_ready), .spdif_out(spdif_out));

  int errs = 0, checks = 0;
  bit done = 0;
  int c_ratio = 0, c_mode = 0;
  bit c_buf = 0, c_na = 0, c_cp = 0, c_pe = 0, c_gen = 0;
  bit [1:0] c_freq = 2'd1;
  logic [15:0] q[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #5; reg_we = 1'b0;
  endtask

  function automatic logic [31:0] exp_ctrl(bit tx);
    return {12'b0, 4'(c_mode), 4'b0, 8'(c_ratio), 2'b0, c_buf, tx};
  endfunction

  function automatic logic [31:0] exp_stat();
    return {24'b0, c_gen, c_pe, c_cp, c_na, 2'b0, c_freq};
  endfunction

  task automatic set_ctrl(bit tx);
    wr(1'b0, exp_ctrl(tx));
    if (!c_buf) q.delete();
  endtask

  task automatic rd_chk(bit a, logic [31:0] exp, string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, req, a ? "status readback" : "control readback", reg_rdata, exp);
  endtask

  task automatic push(logic [15:0] w);
    bit exp_rdy;
    @(negedge clk);
    exp_rdy = c_buf && (q.size() < DEPTH);
    chk(smp_ready == exp_rdy, c_buf ? "R9" : "R10", "smp_ready", smp_ready, exp_rdy);
    smp_valid = 1'b1; smp_data = w;
    @(posedge clk); #5; smp_valid = 1'b0;
    if (exp_rdy) q.push_back(w);
  endtask

  function automatic bit exp_cs(int f);
    case (f)
      1:  return c_na;
      2:  return c_cp;
      3:  return c_pe;
      15: return c_gen;
      24: return (c_freq == 2'd2) || (c_freq == 2'd3);
      25: return (c_freq == 2'd1) || (c_freq == 2'd2);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] exp_audio(logic [15:0] w);
    int m = (c_mode > 8) ? 8 : c_mode;
    return 24'(w) << m;
  endfunction

  task automatic run(int nsub);
    bit h[64];
    bit lvl = 1'b0, cur, ok, fill = 1'b1;
    logic [15:0] wl = '0, wrt = '0;
    logic [31:0] d;
    logic [7:0] pat, pa, pe;
    set_ctrl(1'b1);
    cur = 1'b0;
    for (int s = 0; s < nsub; s++) begin
      bit left = (s % 2 == 0);
      int fr = (s / 2) % NFR;
      bit stable_ok = 1'b1;
      if (left) begin
        if (q.size() >= 2) begin wl = q.pop_front(); wrt = q.pop_front(); fill = 1'b0; end
        else begin wl = '0; wrt = '0; fill = 1'b1; end
      end
      for (int k = 0; k < 64; k++)
        for (int c = 1; c <= c_ratio + 1; c++) begin
          @(posedge clk); #5;
          if (c <= c_ratio) begin
            if (spdif_out !== cur) stable_ok = 1'b0;
          end else begin
            h[k] = spdif_out; cur = spdif_out;
          end
        end
      chk(stable_ok, "R2", "line moved between ticks", 0, 1);
      // R5 preamble shape
      pat = left ? ((fr == 0) ? 8'b11101000 : 8'b11100010) : 8'b11100100;
      for (int i = 0; i < 8; i++) begin
        pa[7-i] = h[i];
        pe[7-i] = pat[7-i] ^ lvl;
      end
      chk(pa == pe, "R5", $sformatf("preamble sub %0d", s), pa, pe);
      // R4 slot-boundary toggles
      ok = 1'b1;
      for (int i = 4; i < 32; i++) if (h[2*i] == h[2*i-1]) ok = 1'b0;
      chk(ok, "R4", $sformatf("biphase boundary sub %0d", s), 0, 1);
      d = '0;
      for (int i = 4; i < 32; i++) d[i] = h[2*i] ^ h[2*i+1];
      chk(d[27:4] == exp_audio(left ? wl : wrt), "R6", $sformatf("audio sub %0d", s),
          d[27:4], exp_audio(left ? wl : wrt));
      chk(d[29:28] == {1'b0, fill}, "R7", $sformatf("validity/user sub %0d", s),
          d[29:28], {1'b0, fill});
      chk((^d[31:4]) == 1'b0, "R7", $sformatf("parity sub %0d", s), ^d[31:4], 0);
      chk(d[30] == exp_cs(fr), "R8", $sformatf("status bit frame %0d", fr), d[30], exp_cs(fr));
      lvl = h[63];
    end
    set_ctrl(1'b0);
    @(posedge clk); #5;
    chk(spdif_out == 1'b0, "R3", "line after disable", spdif_out, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #5;
    chk(spdif_out == 1'b0, "R1", "line in reset", spdif_out, 0);
    chk(smp_ready == 1'b0, "R1", "ready in reset", smp_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk(1'b0, 32'h0, "R1");
    rd_chk(1'b1, 32'h1, "R1");

    // R3: idle while disabled
    begin
      bit idle_ok = 1'b1;
      repeat (20) begin @(posedge clk); #5; if (spdif_out) idle_ok = 1'b0; end
      chk(idle_ok, "R3", "idle while disabled", 0, 1);
    end

    // R10: buffer disabled drops words, then a run shows fill only
    c_ratio = 1; c_mode = 0;
    push(16'h1234); push(16'h5678);
    run(4);

    // R9: fill store, overflow attempt dropped
    c_buf = 1; c_ratio = 0; c_mode = 0; set_ctrl(1'b0);
    for (int i = 0; i < DEPTH + 1; i++) push(16'h1000 + 16'(i * 16'h0111));
    run(12);

    // R10: flush of stored words
    push(16'hAAAA); push(16'h5555); push(16'h0F0F); push(16'hF0F0);
    c_buf = 0; set_ctrl(1'b0);
    c_buf = 1; c_ratio = 2; c_mode = 8; set_ctrl(1'b0);
    run(4);

    // mode corners R6
    c_mode = 8; c_ratio = 0;
    push(16'hFFFF); push(16'h8001);
    run(4);
    c_mode = 13;
    push(16'hC003); push(16'h7FFE);
    run(4);

    // random configurations
    for (int it = 0; it < 6; it++) begin
      int k;
      c_ratio = $urandom_range(0, 6);
      c_mode  = $urandom_range(0, 11);
      c_freq  = 2'($urandom_range(0, 3));
      c_na = 1'($urandom); c_cp = 1'($urandom); c_pe = 1'($urandom); c_gen = 1'($urandom);
      wr(1'b1, exp_stat());
      c_buf = 1; set_ctrl(1'b0);
      rd_chk(1'b0, exp_ctrl(1'b0), "R11");
      rd_chk(1'b1, exp_stat(), "R11");
      k = $urandom_range(0, 8);
      for (int i = 0; i < k; i++) push(16'($urandom));
      run(2 * (q.size() / 2 + 1) + 2);
    end

    // full block with all status fields, R5 block wrap and R8
    c_ratio = 0; c_mode = 0; c_freq = 2'd2;
    c_na = 1; c_cp = 1; c_pe = 1; c_gen = 1;
    wr(1'b1, exp_stat());
    rd_chk(1'b1, exp_stat(), "R11");
    push(16'hBEEF); push(16'hCAFE);
    run(2 * (NFR + 1));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule